// File: doc/BRIEF.md
# Program Counter with Prioritised Next-Address Selection

This block holds the fetch address of a small 8-bit core and decides, on every clock, where that address goes next. There are five ways to update it: an increment after each fetch, an absolute jump, a jump relative to the current address by a signed byte, entry into an interrupt at a supplied vector, and a return from interrupt. A short return stack keeps the addresses that interrupt entry saves. The increment and the relative add use the same adder: its second operand is either the constant one or the sign-extended offset.

When more than one request arrives in the same cycle, a fixed priority picks the winner. Interrupt entry pushes the current counter value, which is the address of the next instruction to run. It then loads the vector. A return pops that value back into the counter. A push onto a full stack or a pop from an empty one leaves the counter unchanged and sets an error flag. That flag stays set until reset.

Top module: `pc_unit`

## Requirements
- R1: While reset is held, and after it is released, `pc_o` equals RESET_VEC (default 0) and `stk_err_o` is 0.
- R2: A fetch with no other request makes `pc_o` one higher on the next cycle, and 0x7FF is followed by 0x000.
- R3: An absolute jump loads `jmp_addr_i` into `pc_o` on the next cycle, and it takes priority over a fetch.
- R4: A relative jump sets `pc_o` to the current value plus `rel_ofs_i` read as a signed two's-complement byte, modulo 2048.
- R5: When an absolute jump and a relative jump are requested together, the absolute jump is taken.
- R6: An interrupt request with free stack space pushes the current `pc_o` and loads `irq_vec_i`. It takes priority over return, both jumps and fetch.
- R7: A return request with no interrupt, on a non-empty stack, loads the most recently pushed address (last in, first out). It takes priority over both jumps and fetch.
- R8: The stack holds STK_DEPTH (default 4) entries. An interrupt request with the stack full leaves `pc_o` and the stack contents unchanged and sets `stk_err_o`.
- R9: A return request on an empty stack leaves `pc_o` unchanged and sets `stk_err_o`. Once set, `stk_err_o` stays 1 until reset.
- R10: With no request active, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_i | input | 1 | Current address consumed; advance by one |
| jmp_i | input | 1 | Absolute jump request |
| jmp_addr_i | input | PC_W | Absolute jump target |
| rel_i | input | 1 | Relative jump request |
| rel_ofs_i | input | OFS_W | Signed relative offset |
| irq_i | input | 1 | Interrupt entry request |
| irq_vec_i | input | PC_W | Interrupt vector |
| reti_i | input | 1 | Return-from-interrupt request |
| pc_o | output | PC_W | Current fetch address |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench uses the default parameters: an 11-bit counter, an 8-bit offset, a four-entry stack and a reset vector of 0. With an 11-bit counter, one jump to 0x7FF followed by a fetch reaches the wrap-around, and a negative offset from 0 reaches the wrap in the other direction. With four entries, the fifth nested interrupt overflows the stack, and the four returns that follow show whether the rejected push disturbed the saved addresses.

// File: rtl/pc_pkg.sv
package pc_pkg;
  // which source feeds the counter register this cycle
  typedef enum logic [2:0] {
    SEL_HOLD  = 3'd0,
    SEL_VEC   = 3'd1,
    SEL_POP   = 3'd2,
    SEL_ABS   = 3'd3,
    SEL_SUM   = 3'd4
  } pc_src_e;
endpackage

// File: rtl/pc_adder.sv
module pc_adder #(
  parameter int PC_W  = 11,
  parameter int OFS_W = 8
) (
  input  logic [PC_W-1:0]  base_i,
  input  logic             rel_sel_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PC_W-1:0]  sum_o
);
  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] opnd;

  // one adder serves both the increment and the relative jump
  always_comb begin
    if (rel_sel_i) opnd = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
    else           opnd = PC_W'(1);
    sum_o = base_i + opnd;
  end
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int PC_W  = 11,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            err_set_i,
  input  logic [PC_W-1:0] push_data_i,
  output logic [PC_W-1:0] pop_data_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            err_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic [PC_W-1:0]  mem_q [DEPTH];

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign err_o   = err_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_i)     cnt_d = cnt_q + CNT_W'(1);
    else if (pop_i) cnt_d = cnt_q - CNT_W'(1);
    err_d = err_q | err_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic wr_en;
    assign wr_en = push_i && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[i] <= '0;
      else if (wr_en) mem_q[i] <= push_data_i;
    end
  end

  always_comb begin
    pop_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) pop_data_o = mem_q[i];
    end
  end

  // R8: occupancy never exceeds the depth
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R8: the selector never pushes onto a full stack
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);
  // R9: the selector never pops an empty stack
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !pop_i);
  // R9: the error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/pc_sel.sv
module pc_sel
  import pc_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  logic            fetch_i,
  input  logic            jmp_i,
  input  logic            rel_i,
  input  logic            irq_i,
  input  logic            reti_i,
  input  logic            full_i,
  input  logic            empty_i,
  input  logic [PC_W-1:0] jmp_addr_i,
  input  logic [PC_W-1:0] irq_vec_i,
  input  logic [PC_W-1:0] pop_data_i,
  input  logic [PC_W-1:0] sum_i,
  output logic [PC_W-1:0] pc_d_o,
  output logic            pc_en_o,
  output logic            push_o,
  output logic            pop_o,
  output logic            err_set_o,
  output logic            rel_sel_o
);
  pc_src_e src;

  // fixed priority: interrupt, return, absolute, relative, increment
  always_comb begin
    src       = SEL_HOLD;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    err_set_o = 1'b0;
    rel_sel_o = 1'b0;
    if (irq_i) begin
      if (full_i) err_set_o = 1'b1;
      else begin
        src    = SEL_VEC;
        push_o = 1'b1;
      end
    end else if (reti_i) begin
      if (empty_i) err_set_o = 1'b1;
      else begin
        src   = SEL_POP;
        pop_o = 1'b1;
      end
    end else if (jmp_i) begin
      src = SEL_ABS;
    end else if (rel_i) begin
      src       = SEL_SUM;
      rel_sel_o = 1'b1;
    end else if (fetch_i) begin
      src = SEL_SUM;
    end
  end

  always_comb begin
    pc_en_o = (src != SEL_HOLD);
    unique case (src)
      SEL_VEC: pc_d_o = irq_vec_i;
      SEL_POP: pc_d_o = pop_data_i;
      SEL_ABS: pc_d_o = jmp_addr_i;
      SEL_SUM: pc_d_o = sum_i;
      default: pc_d_o = '0;
    endcase
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int              PC_W      = 11,
  parameter int              OFS_W     = 8,
  parameter int              STK_DEPTH = 4,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_i,
  input  logic             jmp_i,
  input  logic [PC_W-1:0]  jmp_addr_i,
  input  logic             rel_i,
  input  logic [OFS_W-1:0] rel_ofs_i,
  input  logic             irq_i,
  input  logic [PC_W-1:0]  irq_vec_i,
  input  logic             reti_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             stk_err_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_s;
  logic [PC_W-1:0] pc_q, pc_d, sum, pop_data;
  logic            pc_en, push, pop, err_set, rel_sel, full, empty;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  pc_adder #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
    .base_i(pc_q), .rel_sel_i(rel_sel), .ofs_i(rel_ofs_i), .sum_o(sum)
  );

  pc_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_s), .push_i(push), .pop_i(pop),
    .err_set_i(err_set), .push_data_i(pc_q), .pop_data_o(pop_data),
    .full_o(full), .empty_o(empty), .err_o(stk_err_o)
  );

  pc_sel #(.PC_W(PC_W)) u_sel (
    .fetch_i(fetch_i), .jmp_i(jmp_i), .rel_i(rel_i), .irq_i(irq_i),
    .reti_i(reti_i), .full_i(full), .empty_i(empty),
    .jmp_addr_i(jmp_addr_i), .irq_vec_i(irq_vec_i), .pop_data_i(pop_data),
    .sum_i(sum), .pc_d_o(pc_d), .pc_en_o(pc_en), .push_o(push),
    .pop_o(pop), .err_set_o(err_set), .rel_sel_o(rel_sel)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end
  assign pc_o = pc_q;

  // R6: interrupt with room loads the vector
  a_r6_irq_vec: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_i && !full) |=> (pc_o == $past(irq_vec_i)));
  // R2: lone fetch advances by one
  a_r2_fetch_inc: assert property (@(posedge clk) disable iff (!rst_s)
    (fetch_i && !jmp_i && !rel_i && !irq_i && !reti_i)
      |=> (pc_o == $past(pc_o) + PC_W'(1)));
  // R3: absolute jump wins below interrupt/return
  a_r3_jmp_load: assert property (@(posedge clk) disable iff (!rst_s)
    (jmp_i && !irq_i && !reti_i) |=> (pc_o == $past(jmp_addr_i)));
  // R8: overflow leaves the counter alone
  a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_i && full) |=> $stable(pc_o));
  // R9: underflow leaves the counter alone and flags it
  a_r9_unf_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (reti_i && !irq_i && empty) |=> ($stable(pc_o) && stk_err_o));
  // R10: idle holds
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_s)
    (!fetch_i && !jmp_i && !rel_i && !irq_i && !reti_i) |=> $stable(pc_o));
endmodule

// File: tb/sim_pc_unit.sv
`timescale 1ns/1ps
module sim_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_i, jmp_i, rel_i, irq_i, reti_i;
  logic [10:0] jmp_addr_i, irq_vec_i;
  logic [7:0]  rel_ofs_i;
  logic [10:0] pc_o;
  logic        stk_err_o;
  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  pc_unit u0 (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .jmp_i(jmp_i),
    .jmp_addr_i(jmp_addr_i), .rel_i(rel_i), .rel_ofs_i(rel_ofs_i),
    .irq_i(irq_i), .irq_vec_i(irq_vec_i), .reti_i(reti_i),
    .pc_o(pc_o), .stk_err_o(stk_err_o)
  );

  typedef struct packed {
    logic       f, j, r, i, t;
    logic [10:0] addr;
    logic [7:0]  ofs;
    logic [10:0] vec;
    logic [10:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 11'h000, 11'h001}, // R2
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 11'h000, 11'h002}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 11'h100, 8'h00, 11'h000, 11'h100}, // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 11'h000, 8'h10, 11'h000, 11'h110}, // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 11'h000, 8'hF0, 11'h000, 11'h100}, // R4 negative
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 11'h200, 8'h05, 11'h000, 11'h200}, // R5
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 11'h7FF, 8'h00, 11'h000, 11'h7FF}, // R3 over fetch
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 11'h000, 11'h000}, // R2 wrap
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 11'h000, 8'h80, 11'h000, 11'h780}, // R4 wrap
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 11'h3AA, 8'h00, 11'h040, 11'h040}, // R6
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 11'h000, 11'h041}, // R2
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 11'h000, 8'h00, 11'h050, 11'h050}, // R6 over return
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 11'h333, 8'h00, 11'h000, 11'h041}, // R7 over jump
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 11'h000, 8'h00, 11'h000, 11'h780}, // R7 LIFO
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 11'h000, 11'h780}  // R10
  };

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_i = 0; jmp_i = 0; rel_i = 0; irq_i = 0; reti_i = 0;
    jmp_addr_i = '0; irq_vec_i = '0; rel_ofs_i = '0;
  endtask

  // drive at a falling edge, one rising edge, check at the next falling edge
  task automatic step(input logic f, j, r, i, t, input logic [10:0] addr,
                      input logic [7:0] ofs, input logic [10:0] vec);
    fetch_i = f; jmp_i = j; rel_i = r; irq_i = i; reti_i = t;
    jmp_addr_i = addr; rel_ofs_i = ofs; irq_vec_i = vec;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 pc in reset", pc_o, 11'h000);
    chk("R1 err in reset", {10'b0, stk_err_o}, 11'h000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pc after release", pc_o, 11'h000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b1;
    do_reset();

    for (int k = 0; k < NV; k++) begin
      step(TBL[k].f, TBL[k].j, TBL[k].r, TBL[k].i, TBL[k].t,
           TBL[k].addr, TBL[k].ofs, TBL[k].vec);
      chk($sformatf("table row %0d (R2-R7,R10 group)", k), pc_o, TBL[k].exp);
      chk("R9 no spurious error", {10'b0, stk_err_o}, 11'h000);
    end

    // R8: fill the stack, then overflow
    step(0,0,0,1,0, 11'h0, 8'h0, 11'h010); chk("R6 nest1", pc_o, 11'h010);
    step(0,0,0,1,0, 11'h0, 8'h0, 11'h020); chk("R6 nest2", pc_o, 11'h020);
    step(0,0,0,1,0, 11'h0, 8'h0, 11'h030); chk("R6 nest3", pc_o, 11'h030);
    step(0,0,0,1,0, 11'h0, 8'h0, 11'h040); chk("R6 nest4", pc_o, 11'h040);
    chk("R8 no error at full", {10'b0, stk_err_o}, 11'h000);
    step(1,0,0,1,0, 11'h0, 8'h0, 11'h050);
    chk("R8 overflow holds pc", pc_o, 11'h040);
    chk("R8 overflow flags", {10'b0, stk_err_o}, 11'h001);
    step(0,0,0,0,1, 11'h0, 8'h0, 11'h0); chk("R8 pop after ovf", pc_o, 11'h030);
    step(0,0,0,0,1, 11'h0, 8'h0, 11'h0); chk("R7 pop", pc_o, 11'h020);
    step(0,0,0,0,1, 11'h0, 8'h0, 11'h0); chk("R7 pop", pc_o, 11'h010);
    step(0,0,0,0,1, 11'h0, 8'h0, 11'h0); chk("R7 pop oldest", pc_o, 11'h780);
    chk("R9 sticky after pops", {10'b0, stk_err_o}, 11'h001);

    // R1 again, then R9 underflow
    do_reset();
    chk("R1 err cleared", {10'b0, stk_err_o}, 11'h000);
    step(0,1,0,0,0, 11'h123, 8'h0, 11'h0); chk("R3 jump", pc_o, 11'h123);
    step(0,0,0,0,1, 11'h0, 8'h0, 11'h0);
    chk("R9 underflow holds pc", pc_o, 11'h123);
    chk("R9 underflow flags", {10'b0, stk_err_o}, 11'h001);
    step(1,0,0,0,0, 11'h0, 8'h0, 11'h0);
    chk("R2 fetch after underflow", pc_o, 11'h124);
    chk("R9 flag sticky", {10'b0, stk_err_o}, 11'h001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule